// File: doc/BRIEF.md
# Two-Wire Slave Front End for a 12-Bit Converter

This block receives write traffic for a 12-bit digital-to-analog converter over a two-wire serial bus with SCL and SDA lines. It samples both lines with the system clock. It finds START, repeated START and STOP events, and it compares the incoming 7-bit address with its own address one bit at a time. When the address matches and the direction bit selects a write, the block collects the words that follow. Each word is a pair of bytes carrying a 4-bit command and a 12-bit value. Only a word whose second acknowledge slot completes is passed on.

The block never drives SDA high. It only asserts a pull-low enable, which an external open-drain driver turns into the acknowledge. Six address bits come from a parameter and the lowest bit from a strap input, so several of these slaves can share one bus. A completed word appears on the command and data outputs together with a one-cycle update strobe.

Top module: `i2c_dac_slave`

## Requirements
- R1: While reset is held, and right after it is released, `sda_pull` and `update` are low and `cmd_out` and `data_out` are zero.
- R2: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. A STOP that falls in the same SCL high pulse as the START before it is ignored, and the transfer that START opened continues.
- R3: After START the slave takes 8 bits MSB first. The first seven are the address: its upper six bits equal parameter `ADDR_HI` (default 6'b001000) and its lowest bit equals `addr_sel`. The eighth bit is the direction bit, 0 for write and 1 for read. With the default parameter, a write address byte reads 0x20 when `addr_sel`=0 and 0x22 when `addr_sel`=1.
- R4: The slave drives `sda_pull` high for the ninth clock after a matching address byte, and after each data byte of a write. `sda_pull` changes only while SCL is low, and it is released at the SCL falling edge that ends the ninth clock.
- R5: At the first address bit that differs from the slave's own address, the slave stops responding. It gives no acknowledge and ignores SCL until the next START.
- R6: After a STOP, the slave ignores all SCL activity until the next START. Bytes clocked in during that time get no acknowledge and cause no update.
- R7: In a write, the first data byte holds the command in bits 7..4 and data bits 11..8 in bits 3..0. The second data byte holds data bits 7..0. At the SCL falling edge that ends the second byte's acknowledge, `cmd_out` and `data_out` take the new word and `update` goes high for exactly one clock.
- R8: A STOP or a repeated START that arrives before the committing falling edge discards the partial word. The outputs keep their previous values and no strobe is issued.
- R9: After a committed word, further byte pairs in the same transfer are handled as new words. A repeated START followed by a write address also starts a new word.
- R10: A matching address with the direction bit 1 is acknowledged. The slave then releases SDA and ignores SCL until the next START, so no data byte is acknowledged and no update follows.
- R11: `cmd_out` and `data_out` change only in a cycle where `update` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| addr_sel | input | 1 | Strap that sets the lowest address bit |
| sda_pull | output | 1 | When high, the pad pulls SDA low |
| cmd_out | output | 4 | Command nibble of the last committed word |
| data_out | output | 12 | Data value of the last committed word |
| update | output | 1 | One-cycle strobe when a word commits |

## Verification
Two situations are hard to reach from the pins. The first is a STOP that shares one SCL high pulse with the START before it. The bench produces it by holding SCL high while it first lowers SDA and then raises it again, and only then lets SCL fall and sends a full write. The second is an abort at an exact bit position, here a STOP after four bits of the second data byte. The bench reaches it with a task that clocks out only part of a byte. Because SCL phases last several system clocks, each event clears the synchronizer well before the next one. The bench checks the outputs against its own expected word on every clock, outside a short settling window after each predicted commit.

// File: rtl/i2c_dac_slave.sv
module i2c_dac_slave #(
  parameter logic [5:0] ADDR_HI     = 6'b001000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic        addr_sel,
  output logic        sda_pull,
  output logic [3:0]  cmd_out,
  output logic [11:0] data_out,
  output logic        update
);

  localparam logic [1:0] PH_ADDR = 2'd0;
  localparam logic [1:0] PH_HI   = 2'd1;
  localparam logic [1:0] PH_LO   = 2'd2;

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic active, in_ack, start_pulse, rw_bit;
  logic [3:0] bitcnt;
  logic [1:0] phase;
  logic [7:0] shreg, hi_byte;
  logic [7:0] own_addr;
  logic [2:0] aidx;

  assign scl_s     = scl_sync[SYNC_STAGES-1];
  assign sda_s     = sda_sync[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign own_addr  = {1'b0, ADDR_HI, addr_sel};
  assign aidx      = 3'd6 - bitcnt[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      in_ack      <= 1'b0;
      start_pulse <= 1'b0;
      rw_bit      <= 1'b0;
      bitcnt      <= '0;
      phase       <= PH_ADDR;
      shreg       <= '0;
      hi_byte     <= '0;
      sda_pull    <= 1'b0;
      cmd_out     <= '0;
      data_out    <= '0;
      update      <= 1'b0;
    end else begin
      update <= 1'b0;
      if (scl_fall) start_pulse <= 1'b0;
      if (start_det) begin
        active      <= 1'b1;
        in_ack      <= 1'b0;
        bitcnt      <= '0;
        phase       <= PH_ADDR;
        sda_pull    <= 1'b0;
        start_pulse <= 1'b1;
      end else if (stop_det && !start_pulse) begin
        active   <= 1'b0;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (active) begin
        if (scl_rise && !in_ack) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
          if (phase == PH_ADDR && bitcnt < 4'd7 && sda_s != own_addr[aidx])
            active <= 1'b0;
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack   <= 1'b0;
            sda_pull <= 1'b0;
            bitcnt   <= '0;
            case (phase)
              PH_ADDR: if (rw_bit) active <= 1'b0; else phase <= PH_HI;
              PH_HI:   phase <= PH_LO;
              default: begin
                cmd_out  <= hi_byte[7:4];
                data_out <= {hi_byte[3:0], shreg};
                update   <= 1'b1;
                phase    <= PH_HI;
              end
            endcase
          end else if (bitcnt == 4'd8) begin
            in_ack   <= 1'b1;
            sda_pull <= 1'b1;
            if (phase == PH_ADDR) rw_bit  <= shreg[0];
            if (phase == PH_HI)   hi_byte <= shreg;
          end
        end
      end
    end
  end

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> !update);

  assert_commit_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    update |-> ($past(scl_q) && !$past(scl_s)));

  assert_pull_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) || $fell(sda_pull)) |-> !$past(scl_s));

  assert_idle_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sda_pull);

  assert_outputs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(data_out) || !$stable(cmd_out)) |-> update);

endmodule

// File: tb/i2c_dac_slave_test.sv
module i2c_dac_slave_test;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic addr_sel = 1'b0;
  logic sda_pull, update;
  logic [3:0] cmd_out;
  logic [11:0] data_out;
  logic sda_bus;

  assign sda_bus = sda_drv & ~sda_pull;

  always #10 clk = ~clk;

  i2c_dac_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .addr_sel(addr_sel), .sda_pull(sda_pull), .cmd_out(cmd_out),
    .data_out(data_out), .update(update)
  );

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0;
  logic [3:0]  exp_cmd  = '0;
  logic [11:0] exp_data = '0;
  int exp_upd = 0, seen_upd = 0;
  int commit_seq = 0, last_seq = 0, settle = 0;
  bit mon_on = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    if (update) seen_upd++;
    if (commit_seq != last_seq) begin last_seq = commit_seq; settle = 6; end
    if (settle > 0) settle--;
    else begin
      mon_checks++;
      if (data_out != exp_data || cmd_out != exp_cmd || update) begin
        mon_errors++;
        $display("FAIL R11 held word actual=%0h/%0h/%0b expected=%0h/%0h/0",
                 cmd_out, data_out, update, exp_cmd, exp_data);
      end
    end
  end

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start();
    sda_drv = 1; wt(H); scl = 1; wt(H); sda_drv = 0; wt(H); scl = 0; wt(H);
  endtask

  task automatic i2c_stop();
    sda_drv = 0; wt(H); scl = 1; wt(H); sda_drv = 1; wt(H);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; wt(H); scl = 1; wt(H); scl = 0;
    end
  endtask

  task automatic send_byte(logic [7:0] b, bit exp_ack, string req);
    send_bits(b, 8);
    sda_drv = 1; wt(H); scl = 1; wt(H/2);
    chk(sda_bus == !exp_ack, req, "ack", int'(!sda_bus), int'(exp_ack));
    wt(H/2); scl = 0;
  endtask

  task automatic word(logic [3:0] c, logic [11:0] d, bit acked, string req);
    send_byte({c, d[11:8]}, acked, req);
    send_byte(d[7:0], acked, req);
    if (acked) begin
      exp_cmd = c; exp_data = d; exp_upd++; commit_seq++;
    end
  endtask

  task automatic upd_check(string req);
    wt(8);
    chk(seen_upd == exp_upd, req, "strobe count", seen_upd, exp_upd);
  endtask

  initial begin
    wt(5);
    chk(sda_pull == 0 && update == 0 && cmd_out == 0 && data_out == 0,
        "R1", "reset outputs", {cmd_out, data_out}, 0);
    rst_n = 1; wt(2);
    chk(sda_pull == 0 && update == 0 && data_out == 0, "R1", "after reset", data_out, 0);
    mon_on = 1; wt(H);

    // R3 R4 R7: basic write with addr_sel=0
    i2c_start(); send_byte(8'h20, 1, "R3");
    word(4'h3, 12'hABC, 1, "R7"); i2c_stop(); upd_check("R7");

    // R9: continuous words, then repeated START
    i2c_start(); send_byte(8'h20, 1, "R4");
    word(4'h5, 12'h123, 1, "R9"); word(4'hF, 12'hFFF, 1, "R9");
    i2c_start(); send_byte(8'h20, 1, "R9");
    word(4'h1, 12'h000, 1, "R9"); i2c_stop(); upd_check("R9");

    // R5: mismatch at A1 and at A6
    i2c_start(); send_byte(8'h24, 0, "R5");
    word(4'h7, 12'h777, 0, "R5"); i2c_stop();
    i2c_start(); send_byte(8'hA0, 0, "R5");
    word(4'h7, 12'h777, 0, "R5"); i2c_stop(); upd_check("R5");

    // R3: strap selects lowest address bit
    addr_sel = 1; wt(H);
    i2c_start(); send_byte(8'h22, 1, "R3");
    word(4'h9, 12'h5A5, 1, "R3");
    i2c_start(); send_byte(8'h20, 0, "R3"); i2c_stop(); upd_check("R3");

    // R8: aborts by STOP after first byte, mid second byte, and by repeated START
    i2c_start(); send_byte(8'h22, 1, "R8");
    send_byte(8'h4D, 1, "R8"); i2c_stop();
    i2c_start(); send_byte(8'h22, 1, "R8");
    send_byte(8'h4D, 1, "R8"); send_bits(8'hEE, 4); i2c_stop();
    i2c_start(); send_byte(8'h22, 1, "R8");
    send_byte(8'h6E, 1, "R8");
    i2c_start(); send_byte(8'h22, 1, "R8");
    word(4'hC, 12'h321, 1, "R8"); i2c_stop(); upd_check("R8");

    // R10: read address acked, later bytes ignored
    i2c_start(); send_byte(8'h23, 1, "R10");
    word(4'h2, 12'h222, 0, "R10"); i2c_stop(); upd_check("R10");

    // R6: after STOP, clocking without START is ignored
    scl = 0; wt(H);
    send_byte(8'h22, 0, "R6"); word(4'h8, 12'h888, 0, "R6");
    i2c_stop(); upd_check("R6");

    // R2: STOP inside the START's high pulse is ignored
    sda_drv = 1; wt(H); scl = 1; wt(H);
    sda_drv = 0; wt(H); sda_drv = 1; wt(H); scl = 0; wt(H);
    send_byte(8'h22, 1, "R2"); word(4'hE, 12'hDEF, 1, "R2");
    i2c_stop(); upd_check("R2");

    wt(20);
    checks += mon_checks; errors += mon_errors;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks += mon_checks + 1; errors += mon_errors + 1;
    $display("FAIL watchdog run did not complete actual=hang expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule